// File: doc/BRIEF.md
# Token-Passing Result Handshake Distributor

A shared compute resource delivers its results one after another through a single request/acknowledge pair. Each result belongs to a different scheduled operation, and each operation has its own consumer. This block sits after that shared output. It turns the one time-shared request into a set of ordered four-phase handshakes, one per operation. Ownership of the shared request is held by a single token that moves around a ring of slots. Slot k serves the k-th result of a run, so slots are visited in the order in which the operations were scheduled.

An environment start signal places the token in slot 0. The slot that holds the token waits for the shared request. It then acknowledges that request at once and raises its own output request. When its consumer acknowledges, the slot drops the shared acknowledge. When the shared request returns low, the slot drops its output request and hands the token to the next slot.

A slot whose result has no consumer inside the circuit is built as a stub. The stub acknowledges by itself and never raises an output request. After the last slot completes, done rises. Start and done then fall in that same order, which closes the four-phase exchange with the environment.

Top module: `result_distributor`

## Requirements
- R1: After reset, and in any cycle before start has been seen, done_o, res_ack_o and every op_req_o bit are 0. A shared request that arrives before start draws no acknowledge.
- R2: A start that is sampled high while the block is idle gives the token to slot 0. The first shared request sampled after that raises res_ack_o and op_req_o[0] in the next cycle.
- R3: While the active slot's op_ack_i bit stays low, res_ack_o and that slot's op_req_o bit stay high.
- R4: When the active consumer's op_ack_i is sampled high, res_ack_o falls in the next cycle. The slot's op_req_o stays high for as long as res_req_i stays high.
- R5: When res_req_i is sampled low after the acknowledge has been released, the active op_req_o bit falls in the next cycle and the token moves to the next slot. At most one slot holds the token at any time.
- R6: A slot whose CONSUMED_MASK bit is 0 is a stub. It asserts res_ack_o for exactly one cycle per request and never raises its op_req_o bit. In the default mask 4'b1011, slot 2 is the stub.
- R7: A slot holding the token does not respond to res_req_i while its own op_ack_i bit is still high from an earlier exchange. It responds once that bit is low.
- R8: done_o rises in the cycle after the last slot hands off the token. It stays high while start_i is high, and shared requests draw no acknowledge during that time. It falls in the cycle after start_i is sampled low.
- R9: After done_o has fallen, a new start gives the token to slot 0 again.
- R10: If the consumer's acknowledge rises in the same cycle that res_req_i falls, the release of res_ack_o, the fall of op_req_o and the token hand-off all take effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Environment start; high means inputs are valid |
| done_o | output | 1 | High when all results of the run have been delivered |
| res_req_i | input | 1 | Request from the shared output latch controller |
| res_ack_o | output | 1 | Acknowledge to the shared output latch controller |
| op_req_o | output | N_SLOTS | Per-operation output request, bit k for slot k |
| op_ack_i | input | N_SLOTS | Per-operation consumer acknowledge, bit k for slot k |

## Verification
In one cycle the active slot can see both its consumer's acknowledge and the fall of the shared request, so acknowledge release and token hand-off happen together. The bench provokes this by raising op_ack_i[1] and lowering res_req_i in the same vector while slot 1 is serving. It then expects res_ack_o low, op_req_o all zero, and slot 2 answering the very next request. Any design that serialises the two events leaves an output request high for one extra cycle, and that vector reports the difference.

// File: rtl/dist_pkg.sv
package dist_pkg;
    typedef enum logic [1:0] {
        SL_IDLE,
        SL_WAIT,
        SL_SERVE,
        SL_DRAIN
    } slot_st_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_DONE
    } seq_st_e;

    typedef struct packed {
        slot_st_e st;
    } slot_regs_t;

    typedef struct packed {
        seq_st_e st;
    } seq_regs_t;
endpackage

// File: rtl/dist_slot.sv
module dist_slot
    import dist_pkg::*;
#(
    parameter bit HAS_CONSUMER = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic res_req_i,
    input  logic op_ack_i,
    output logic res_ack_o,
    output logic op_req_o,
    output logic active_o,
    output logic finish_o
);
    slot_regs_t r_d, r_q;
    logic cons_done;
    logic may_raise;

    assign cons_done = HAS_CONSUMER ? op_ack_i : 1'b1;
    assign may_raise = HAS_CONSUMER ? !op_ack_i : 1'b1;

    always_comb begin
        r_d      = r_q;
        finish_o = 1'b0;
        case (r_q.st)
            SL_IDLE: begin
                if (take_i) r_d.st = SL_WAIT;
            end
            SL_WAIT: begin
                if (res_req_i && may_raise) r_d.st = SL_SERVE;
            end
            SL_SERVE: begin
                if (cons_done) begin
                    if (!res_req_i) begin
                        r_d.st   = SL_IDLE;
                        finish_o = 1'b1;
                    end else begin
                        r_d.st = SL_DRAIN;
                    end
                end
            end
            SL_DRAIN: begin
                if (!res_req_i) begin
                    r_d.st   = SL_IDLE;
                    finish_o = 1'b1;
                end
            end
            default: r_d.st = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.st <= SL_IDLE;
        else        r_q <= r_d;
    end

    assign res_ack_o = (r_q.st == SL_SERVE);
    assign op_req_o  = HAS_CONSUMER && ((r_q.st == SL_SERVE) || (r_q.st == SL_DRAIN));
    assign active_o  = (r_q.st != SL_IDLE);

    generate
        if (HAS_CONSUMER) begin : g_cons_chk
            // R3
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_ack_o && !op_ack_i) |=> (res_ack_o && op_req_o));
            // R4
            release_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_ack_o && op_ack_i) |=> !res_ack_o);
            // R5
            drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_req_o && !res_ack_o && !res_req_i) |=> !op_req_o);
        end else begin : g_stub_chk
            // R6
            stub_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                res_ack_o |=> !res_ack_o);
        end
    endgenerate
endmodule

// File: rtl/dist_seq.sv
module dist_seq
    import dist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_finish_i,
    output logic launch_o,
    output logic done_o
);
    seq_regs_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        launch_o = 1'b0;
        case (s_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    s_d.st   = SQ_RUN;
                    launch_o = 1'b1;
                end
            end
            SQ_RUN: begin
                if (last_finish_i) s_d.st = SQ_DONE;
            end
            SQ_DONE: begin
                if (!start_i) s_d.st = SQ_IDLE;
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.st <= SQ_IDLE;
        else        s_q <= s_d;
    end

    assign done_o = (s_q.st == SQ_DONE);

    // R8
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> !$past(start_i));
    // R8
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(last_finish_i));
endmodule

// File: rtl/result_distributor.sv
module result_distributor #(
    parameter int                 N_SLOTS       = 4,
    parameter logic [N_SLOTS-1:0] CONSUMED_MASK = 4'b1011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               done_o,
    input  logic               res_req_i,
    output logic               res_ack_o,
    output logic [N_SLOTS-1:0] op_req_o,
    input  logic [N_SLOTS-1:0] op_ack_i
);
    localparam int LAST = N_SLOTS - 1;

    logic               launch;
    logic [N_SLOTS-1:0] take;
    logic [N_SLOTS-1:0] finish;
    logic [N_SLOTS-1:0] acks;
    logic [N_SLOTS-1:0] active;

    dist_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .last_finish_i(finish[LAST]),
        .launch_o     (launch),
        .done_o       (done_o)
    );

    genvar k;
    generate
        for (k = 0; k < N_SLOTS; k++) begin : g_slot
            if (k == 0) begin : g_head
                assign take[k] = launch;
            end else begin : g_link
                assign take[k] = finish[k-1];
            end
            dist_slot #(.HAS_CONSUMER(CONSUMED_MASK[k])) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .take_i   (take[k]),
                .res_req_i(res_req_i),
                .op_ack_i (op_ack_i[k]),
                .res_ack_o(acks[k]),
                .op_req_o (op_req_o[k]),
                .active_o (active[k]),
                .finish_o (finish[k])
            );
        end
    endgenerate

    assign res_ack_o = |acks;

    // R5
    token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active));
    // R2
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_ack_o) |-> $past(res_req_i));
    // R8
    quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!res_ack_o && (op_req_o == '0)));
endmodule

// File: tb/sim_result_distributor.sv
`timescale 1ns/1ps
module sim_result_distributor;
    localparam int N = 4;
    localparam int NV = 21;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         res_req_i = 1'b0;
    logic [N-1:0] op_ack_i = '0;
    logic         done_o;
    logic         res_ack_o;
    logic [N-1:0] op_req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    result_distributor #(.N_SLOTS(N), .CONSUMED_MASK(4'b1011)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .done_o   (done_o),
        .res_req_i(res_req_i),
        .res_ack_o(res_ack_o),
        .op_req_o (op_req_o),
        .op_ack_i (op_ack_i)
    );

    // {start, req, ack[3:0], exp_done, exp_rack, exp_oreq[3:0]}
    localparam logic [11:0] VEC [NV] = '{
        12'b0_1_0000_0_0_0000,
        12'b1_0_0000_0_0_0000,
        12'b1_1_0000_0_1_0001,
        12'b1_1_0000_0_1_0001,
        12'b1_1_0001_0_0_0001,
        12'b1_0_0001_0_0_0000,
        12'b1_0_0000_0_0_0000,
        12'b1_1_0010_0_0_0000,
        12'b1_1_0000_0_1_0010,
        12'b1_0_0010_0_0_0000,
        12'b1_1_0000_0_1_0000,
        12'b1_1_0000_0_0_0000,
        12'b1_0_0000_0_0_0000,
        12'b1_1_0000_0_1_1000,
        12'b1_1_1000_0_0_1000,
        12'b1_0_1000_1_0_0000,
        12'b1_0_0000_1_0_0000,
        12'b1_1_0000_1_0_0000,
        12'b0_0_0000_0_0_0000,
        12'b1_0_0000_0_0_0000,
        12'b1_1_0000_0_1_0001
    };

    function automatic string tag(input int i);
        case (i)
            0:        return "R1";
            1, 2:     return "R2";
            3:        return "R3";
            4:        return "R4";
            5, 6, 12: return "R5";
            7, 8:     return "R7";
            9:        return "R10";
            10, 11:   return "R6";
            13, 14:   return "R5";
            15, 16, 17, 18: return "R8";
            default:  return "R9";
        endcase
    endfunction

    task automatic check(input string rq, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {done,ack,req} actual %b expected %b", rq, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {done_o, res_ack_o, op_req_o}, 6'b0);
        for (int i = 0; i < NV; i++) begin
            start_i   = VEC[i][11];
            res_req_i = VEC[i][10];
            op_ack_i  = VEC[i][9:6];
            @(negedge clk);
            check(tag(i), {done_o, res_ack_o, op_req_o}, VEC[i][5:0]);
        end
        // R1: reset in the middle of a serve clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {done_o, res_ack_o, op_req_o}, 6'b0);
        start_i   = 1'b0;
        res_req_i = 1'b1;
        rst_n     = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1: request before start is ignored
        check("R1", {done_o, res_ack_o, op_req_o}, 6'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule